// File: doc/BRIEF.md
# Interleaved I/Q Input Formatter

This block sits at the entry of a complex baseband data path. A single 18-bit parallel bus carries in-phase and quadrature words alternately, and each word is qualified by a strobe on the parallel data clock. The formatter pairs every I word with the Q word that follows it. It then presents the pair as one complex sample, with both components side by side and a single-cycle valid pulse.

On the same clock, the block captures a 3-bit profile select and an update request. It forwards them to the control path one cycle later. With each complex sample it also reports two things: the profile that was present when the sample completed, and whether an update was requested while that sample was being gathered.

A realignment input lets upstream logic restore the pairing after a slip. Any half-collected pair is dropped, and the next qualified word counts as I again.

Top module: `iqf_formatter`

## Requirements
- R1: While reset is held and on the first cycle after it, `smp_vld`, `smp_i`, `smp_q`, `smp_prof`, `smp_upd`, `ctl_prof` and `ctl_upd` are all zero. The next qualified word is treated as I.
- R2: Only cycles with `word_vld` high count as words. After reset, odd-numbered words are I and even-numbered words are Q. On the clock edge that takes a Q word, `smp_i` takes the preceding I word and `smp_q` takes the Q word.
- R3: `smp_vld` is high for exactly the one cycle after the edge that takes a Q word, and it is low in every other cycle.
- R4: An I word with no Q word after it never raises `smp_vld`. Any number of cycles with `word_vld` low between an I word and its Q word leave the pairing intact.
- R5: When `realign` is high in a cycle, any stored I word is discarded. A word qualified in that same cycle is taken as I; otherwise the next qualified word is taken as I. No sample is emitted on the edge of a realign cycle.
- R6: `smp_prof` carries the value of `prof_sel` from the cycle in which the Q word of that sample was taken.
- R7: `smp_upd` is 1 when `upd_req` was high in at least one cycle after the previous sample's Q cycle, up to and including this sample's Q cycle. For the first sample, the window runs from the end of reset. Requests are never lost between samples.
- R8: `ctl_prof` and `ctl_upd` show `prof_sel` and `upd_req` from the previous cycle, whatever the state of `word_vld`.
- R9: `smp_i`, `smp_q`, `smp_prof` and `smp_upd` hold their values in every cycle where `smp_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel data clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_vld | input | 1 | Qualifies `word_in` in this cycle |
| word_in | input | 18 | Interleaved I/Q data word |
| realign | input | 1 | Drop any pending I word; restart the pairing at I |
| prof_sel | input | 3 | Profile select, captured every cycle |
| upd_req | input | 1 | Update request, captured every cycle |
| smp_vld | output | 1 | One-cycle pulse marking a new complex sample |
| smp_i | output | 18 | In-phase component of the sample |
| smp_q | output | 18 | Quadrature component of the sample |
| smp_prof | output | 3 | Profile select from the sample's Q cycle |
| smp_upd | output | 1 | Update was requested during the sample's collection |
| ctl_prof | output | 3 | Profile select, delayed one cycle |
| ctl_upd | output | 1 | Update request, delayed one cycle |

## Verification
The pairing is driven with four input patterns:
- Back-to-back words, which show whether the I/Q phase toggles on every qualified word.
- Words with idle gaps inside and between pairs, which show whether unqualified cycles are wrongly counted as words.
- Realignment pulses that arrive with a word, without a word, and on a lone pending I, which separate a correct restart at I from a stale half-pair.
- Profile and update activity placed on I cycles, Q cycles and idle cycles, which shows whether the side-band is tied to the Q capture cycle and whether update requests accumulate across the whole pair.

// File: rtl/iqf_pkg.sv
// Shared definitions for the interleaved I/Q formatter.
// Assumes: the word width and the profile width are set as top-level parameters.
package iqf_pkg;
    // Which half of a complex pair the next qualified word belongs to.
    typedef enum logic [0:0] {
        PH_EXPECT_I = 1'b0,
        PH_EXPECT_Q = 1'b1
    } pair_phase_e;
endpackage

// File: rtl/iqf_phase_tracker.sv
// Tracks whether the next qualified word is I or Q and marks each
// captured word as I or Q.
// Assumes: realign takes priority over any pending Q expectation.
module iqf_phase_tracker
    import iqf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic word_vld,
    input  logic realign,
    output logic take_i,
    output logic take_q
);
    pair_phase_e phase_q;

    // Classify the word in this cycle.
    always_comb begin
        take_i = word_vld && (realign || (phase_q == PH_EXPECT_I));
        take_q = word_vld && !realign && (phase_q == PH_EXPECT_Q);
    end

    // Advance the phase on each qualified word or on a realignment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_EXPECT_I;
        end else if (take_i) begin
            phase_q <= PH_EXPECT_Q;
        end else if (take_q || realign) begin
            phase_q <= PH_EXPECT_I;
        end
    end
endmodule

// File: rtl/iqf_word_pair.sv
// Holds the I word and, on its matching Q word, registers the complex
// sample with a one-cycle valid pulse.
// Assumes: take_i and take_q are never high together.
module iqf_word_pair #(
    parameter int WORD_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic              take_q,
    input  logic [WORD_W-1:0] word_in,
    output logic              smp_vld,
    output logic [WORD_W-1:0] smp_i,
    output logic [WORD_W-1:0] smp_q
);
    logic [WORD_W-1:0] held_i;

    // Keep the most recent I word until its partner arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_i <= '0;
        end else if (take_i) begin
            held_i <= word_in;
        end
    end

    // Emit the complex sample on the edge of the Q word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_vld <= 1'b0;
            smp_i   <= '0;
            smp_q   <= '0;
        end else begin
            smp_vld <= take_q;
            if (take_q) begin
                smp_i <= held_i;
                smp_q <= word_in;
            end
        end
    end
endmodule

// File: rtl/iqf_ctl_sampler.sv
// Captures profile select and update request on every clock, and tags
// each complex sample with its profile and with accumulated update requests.
// Assumes: take_q marks the cycle that completes a sample.
module iqf_ctl_sampler #(
    parameter int PROF_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_q,
    input  logic [PROF_W-1:0] prof_sel,
    input  logic              upd_req,
    output logic [PROF_W-1:0] ctl_prof,
    output logic              ctl_upd,
    output logic [PROF_W-1:0] smp_prof,
    output logic              smp_upd
);
    logic upd_seen;

    // Pass the control lines straight on with one register of delay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_prof <= '0;
            ctl_upd  <= 1'b0;
        end else begin
            ctl_prof <= prof_sel;
            ctl_upd  <= upd_req;
        end
    end

    // Collect update requests between sample completions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_seen <= 1'b0;
        end else if (take_q) begin
            upd_seen <= 1'b0;
        end else if (upd_req) begin
            upd_seen <= 1'b1;
        end
    end

    // Tag the completed sample with its side-band values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_prof <= '0;
            smp_upd  <= 1'b0;
        end else if (take_q) begin
            smp_prof <= prof_sel;
            smp_upd  <= upd_seen | upd_req;
        end
    end
endmodule

// File: rtl/iqf_formatter.sv
// Top level: turns an interleaved I/Q word stream into parallel complex
// samples and captures the profile and update lines on the same clock.
// Assumes: all inputs are synchronous to clk; reset is synchronous active-low.
module iqf_formatter #(
    parameter int WORD_W = 18,
    parameter int PROF_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word_in,
    input  logic              realign,
    input  logic [PROF_W-1:0] prof_sel,
    input  logic              upd_req,
    output logic              smp_vld,
    output logic [WORD_W-1:0] smp_i,
    output logic [WORD_W-1:0] smp_q,
    output logic [PROF_W-1:0] smp_prof,
    output logic              smp_upd,
    output logic [PROF_W-1:0] ctl_prof,
    output logic              ctl_upd
);
    logic take_i;
    logic take_q;

    iqf_phase_tracker u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_vld (word_vld),
        .realign  (realign),
        .take_i   (take_i),
        .take_q   (take_q)
    );

    iqf_word_pair #(.WORD_W(WORD_W)) u_pair (
        .clk     (clk),
        .rst_n   (rst_n),
        .take_i  (take_i),
        .take_q  (take_q),
        .word_in (word_in),
        .smp_vld (smp_vld),
        .smp_i   (smp_i),
        .smp_q   (smp_q)
    );

    iqf_ctl_sampler #(.PROF_W(PROF_W)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_q   (take_q),
        .prof_sel (prof_sel),
        .upd_req  (upd_req),
        .ctl_prof (ctl_prof),
        .ctl_upd  (ctl_upd),
        .smp_prof (smp_prof),
        .smp_upd  (smp_upd)
    );
endmodule

// File: rtl/iqf_formatter_checker.sv
// Port-level temporal checks for the formatter, bound to every instance.
module iqf_formatter_checker #(
    parameter int WORD_W = 18,
    parameter int PROF_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              word_vld,
    input logic              realign,
    input logic [PROF_W-1:0] prof_sel,
    input logic              upd_req,
    input logic              smp_vld,
    input logic [WORD_W-1:0] smp_i,
    input logic [WORD_W-1:0] smp_q,
    input logic [PROF_W-1:0] smp_prof,
    input logic              smp_upd,
    input logic [PROF_W-1:0] ctl_prof,
    input logic              ctl_upd
);
    // R3: a valid pulse lasts a single cycle.
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |=> !smp_vld);

    // R4: a sample needs a qualified word that was not a realign word.
    a_r4_needs_q_word: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |-> ($past(word_vld) && !$past(realign)));

    // R5: no sample follows a realign cycle.
    a_r5_realign_no_out: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(realign)) |-> !smp_vld);

    // R6: the sample profile comes from the Q capture cycle.
    a_r6_prof_tag: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |-> (smp_prof == $past(prof_sel)));

    // R7: an update request in the Q cycle is always reported.
    a_r7_upd_at_q: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && $past(upd_req)) |-> smp_upd);

    // R8: the control lines follow the inputs after one cycle.
    a_r8_ctl_follow: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((ctl_prof == $past(prof_sel)) && (ctl_upd == $past(upd_req))));

    // R9: the sample fields hold between pulses.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_vld && $past(rst_n)) |->
            ($stable(smp_i) && $stable(smp_q) && $stable(smp_prof) && $stable(smp_upd)));
endmodule

bind iqf_formatter iqf_formatter_checker #(.WORD_W(WORD_W), .PROF_W(PROF_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_vld (word_vld),
    .realign  (realign),
    .prof_sel (prof_sel),
    .upd_req  (upd_req),
    .smp_vld  (smp_vld),
    .smp_i    (smp_i),
    .smp_q    (smp_q),
    .smp_prof (smp_prof),
    .smp_upd  (smp_upd),
    .ctl_prof (ctl_prof),
    .ctl_upd  (ctl_upd)
);

// File: tb/iqf_formatter_tb_top.sv
// Self-checking bench with a behavioural queue model compared every clock.
module iqf_formatter_tb_top;
    localparam int WORD_W = 18;
    localparam int PROF_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              word_vld = 1'b0;
    logic [WORD_W-1:0] word_in = '0;
    logic              realign = 1'b0;
    logic [PROF_W-1:0] prof_sel = '0;
    logic              upd_req = 1'b0;
    logic              smp_vld;
    logic [WORD_W-1:0] smp_i;
    logic [WORD_W-1:0] smp_q;
    logic [PROF_W-1:0] smp_prof;
    logic              smp_upd;
    logic [PROF_W-1:0] ctl_prof;
    logic              ctl_upd;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference model state.
    logic [WORD_W-1:0] pend[$];
    bit                acc_upd = 1'b0;
    bit                e_vld = 1'b0;
    logic [WORD_W-1:0] e_i = '0;
    logic [WORD_W-1:0] e_q = '0;
    logic [PROF_W-1:0] e_prof = '0;
    bit                e_upd = 1'b0;
    logic [PROF_W-1:0] e_cp = '0;
    bit                e_cu = 1'b0;

    always #5 clk = ~clk;

    iqf_formatter #(.WORD_W(WORD_W), .PROF_W(PROF_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_in(word_in),
        .realign(realign), .prof_sel(prof_sel), .upd_req(upd_req),
        .smp_vld(smp_vld), .smp_i(smp_i), .smp_q(smp_q), .smp_prof(smp_prof),
        .smp_upd(smp_upd), .ctl_prof(ctl_prof), .ctl_upd(ctl_upd)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R3/R4/R5", "smp_vld", 32'(smp_vld), 32'(e_vld));
        check(e_vld ? "R2" : "R9", "smp_i", 32'(smp_i), 32'(e_i));
        check(e_vld ? "R2" : "R9", "smp_q", 32'(smp_q), 32'(e_q));
        check("R6", "smp_prof", 32'(smp_prof), 32'(e_prof));
        check("R7", "smp_upd", 32'(smp_upd), 32'(e_upd));
        check("R8", "ctl_prof", 32'(ctl_prof), 32'(e_cp));
        check("R8", "ctl_upd", 32'(ctl_upd), 32'(e_cu));
    endtask

    // One clock: drive, let the edge pass, update the model, compare.
    task automatic step(bit v, logic [WORD_W-1:0] w, bit ra, logic [PROF_W-1:0] p, bit u);
        @(negedge clk);
        word_vld = v; word_in = w; realign = ra; prof_sel = p; upd_req = u;
        @(posedge clk);
        #2;
        e_vld = 1'b0;
        e_cp = p;
        e_cu = u;
        if (ra) pend.delete();
        if (v) begin
            if (pend.size() == 0) begin
                pend.push_back(w);
            end else begin
                e_i = pend.pop_front();
                e_q = w;
                e_prof = p;
                e_upd = acc_upd | u;
                acc_upd = 1'b0;
                e_vld = 1'b1;
            end
        end
        if (!e_vld) acc_upd = acc_upd | u;
        compare_all();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        word_vld = 1'b0; realign = 1'b0; upd_req = 1'b0;
        prof_sel = 3'd5; word_in = 18'h2AAAA;
        repeat (3) @(posedge clk);
        #2;
        pend.delete();
        acc_upd = 1'b0;
        e_vld = 1'b0; e_i = '0; e_q = '0; e_prof = '0; e_upd = 1'b0; e_cp = '0; e_cu = 1'b0;
        compare_all();  // R1: outputs cleared while held in reset
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic rnd_steps(int n, int vld_pct, int ra_pct, int upd_pct);
        for (int k = 0; k < n; k++) begin
            step(($urandom % 100) < vld_pct, WORD_W'($urandom), ($urandom % 100) < ra_pct,
                 PROF_W'($urandom), ($urandom % 100) < upd_pct);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED));
        do_reset();
        // R1: first cycle after reset, idle inputs
        step(0, 18'h0, 0, 3'd0, 0);
        // R2/R3: back-to-back pairs
        step(1, 18'h11111, 0, 3'd1, 0);
        step(1, 18'h22222, 0, 3'd2, 0);
        step(1, 18'h33333, 0, 3'd3, 0);
        step(1, 18'h04444, 0, 3'd4, 0);
        // R4: gaps inside a pair
        step(1, 18'h15555, 0, 3'd1, 0);
        step(0, 18'h3FFFF, 0, 3'd6, 1);   // R7: update on idle cycle
        step(0, 18'h3FFFF, 0, 3'd6, 0);
        step(1, 18'h26666, 0, 3'd7, 0);   // R6: profile at Q
        step(0, 18'h0, 0, 3'd0, 0);       // R9: hold
        // R5: realign discards lone I, same-cycle word becomes I
        step(1, 18'h0AAAA, 0, 3'd2, 0);
        step(1, 18'h0BBBB, 1, 3'd3, 0);
        step(1, 18'h0CCCC, 0, 3'd4, 1);   // R7: update at Q
        // R5: realign without word
        step(1, 18'h0DDDD, 0, 3'd1, 0);
        step(0, 18'h0, 1, 3'd1, 0);
        step(1, 18'h0EEEE, 0, 3'd2, 0);
        step(1, 18'h0FFFF, 0, 3'd3, 0);
        // R7: update on I cycle only
        step(1, 18'h12345, 0, 3'd0, 1);
        step(1, 18'h23456, 0, 3'd5, 0);
        // R4: lone I then reset
        step(1, 18'h3ABCD, 0, 3'd0, 0);
        do_reset();
        step(1, 18'h01234, 0, 3'd6, 0);   // R1: new pairing starts at I
        step(1, 18'h05678, 0, 3'd7, 0);
        // Mixed random traffic
        rnd_steps(400, 100, 0, 20);
        rnd_steps(600, 50, 5, 10);
        rnd_steps(600, 80, 15, 30);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule